// File: doc/BRIEF.md
# SPI Master FIFO and Interrupt Front End

This block sits between a register bus and the serial shift engine of an SPI master. It holds two queues of 32-bit words, eight entries each. Software fills the transmit queue and drains the receive queue through one shared data address. Writing that address pushes a word toward the shifter, and reading it pops the oldest received word. The shift engine takes transmit words and delivers received words through single-cycle handshakes.

A control register holds a fill threshold for each queue and two self-clearing flush bits. A status register tells software whether received data is waiting. Three event flags share one address: receive threshold reached, receive overrun and transmit complete. Reading that address returns the flags, and writing a 1 to a flag bit clears that flag. Each of the two receive flags has its own enable, and the single interrupt output is the OR of the enabled flags.

Register word addresses are: 0 control, 1 status, 2 interrupt enable, 3 interrupt flags and clear, 4 data. Read data is combinational, so it is valid in the same cycle as the read strobe.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset both queues are empty, `tx_valid` and `irq` are 0, and the status, enable and flag registers all read 0.
- R2: Words written to address 4 are presented on `tx_data` in write order. `tx_valid` is high while the transmit queue holds data, and each cycle with `tx_take` and `tx_valid` both high advances to the next word.
- R3: A write to address 4 while the transmit queue holds 8 words is dropped, and the 8 stored words are presented unchanged and in order.
- R4: Each `rx_push` stores `rx_data`. Reads of address 4 return received words oldest first and pop them. Status bit 0 reads 1 exactly when the receive queue is not empty.
- R5: A read of address 4 with the receive queue empty returns 0 and leaves the queue empty.
- R6: An `rx_push` while the receive queue holds 8 words, with no pop in the same cycle, discards the word and sets flag bit 0 (overrun).
- R7: An `rx_push` in the same cycle as a pop from a full receive queue is accepted, and no overrun is flagged.
- R8: Control bits 3:0 hold the receive threshold. Flag bit 9 reads 1 while the threshold is nonzero and the receive occupancy is at least the threshold. Flag bit 3 is set on the clock edge after that condition holds. A threshold of 0 never sets either bit.
- R9: Writing 1 to bit 0, 3 or 4 of address 3 clears that flag. If the set condition of a flag holds in the same cycle as its clear, the set takes priority.
- R10: Flag bit 4 is set once when the transmit queue becomes empty while `shifter_idle` is high. It is not set after reset.
- R11: Control bit 12 empties the transmit queue and bit 4 empties the receive queue in one cycle. These flush bits read back as 0, and the thresholds in bits 11:8 and 3:0 read back as written.
- R12: `irq` is high exactly when (flag bit 3 and enable bit 3) or (flag bit 0 and enable bit 0) is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_data | output | DW | Oldest transmit word |
| tx_take | input | 1 | Shifter takes the presented word |
| shifter_idle | input | 1 | Shift engine is idle |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_data | input | DW | Received word |
| irq | output | 1 | Interrupt request |

## Verification
Two cases make a receive event fall in the same cycle as a software action on the same state. In the first, a software pop of a full receive queue meets a shifter push. The bench raises `rx_push` and the data read strobe together, then drains the queue to confirm that all nine words come out in order and that flag bit 0 stays clear. In the second, a write-1-to-clear of the threshold flag lands while the occupancy still meets the threshold. The bench reads the flag back as 1 in that case, and then reads it as 0 after a pop drops the occupancy below the threshold and the clear is repeated.

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_take,
  input  logic          shifter_idle,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_CTL  = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_IEN  = AW'(2);
  localparam logic [AW-1:0] A_IFLG = AW'(3);
  localparam logic [AW-1:0] A_DATA = AW'(4);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [3:0]    tx_thr, rx_thr;
  logic          en_rc, en_ov;
  logic          rc_flag, ov_flag, td_flag, td_prev;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  wire wr_ctl  = bus_wr && bus_addr == A_CTL;
  wire wr_ien  = bus_wr && bus_addr == A_IEN;
  wire wr_clr  = bus_wr && bus_addr == A_IFLG;
  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire rd_data = bus_rd && bus_addr == A_DATA;

  wire tx_flush = wr_ctl && bus_wdata[12];
  wire rx_flush = wr_ctl && bus_wdata[4];
  wire tx_full  = 32'(tx_cnt) == DEPTH;
  wire rx_full  = 32'(rx_cnt) == DEPTH;
  wire rx_nempty = rx_cnt != '0;

  wire tx_push = wr_data && !tx_full;
  wire tx_pop  = tx_take && tx_valid;
  wire rx_pop  = rd_data && rx_nempty;
  wire rx_acc  = rx_push && (!rx_full || rx_pop);
  wire ov_evt  = rx_push && rx_full && !rx_pop && !rx_flush;
  wire thr_hit = rx_thr != 4'd0 && 32'(rx_cnt) >= 32'(rx_thr);
  wire td_cond = tx_cnt == '0 && shifter_idle;

  assign tx_valid = tx_cnt != '0;
  assign tx_data  = tx_mem[tx_rp];
  assign irq      = (rc_flag && en_rc) || (ov_flag && en_ov);

  always_ff @(posedge clk) begin
    if (!rst_n || tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) begin
        tx_mem[tx_wp] <= bus_wdata;
        tx_wp <= nxt(tx_wp);
      end
      if (tx_pop) tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_acc) begin
        rx_mem[rx_wp] <= rx_data;
        rx_wp <= nxt(rx_wp);
      end
      if (rx_pop) rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_acc) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr <= '0; rx_thr <= '0; en_rc <= 1'b0; en_ov <= 1'b0;
      rc_flag <= 1'b0; ov_flag <= 1'b0; td_flag <= 1'b0; td_prev <= 1'b1;
    end else begin
      if (wr_ctl) begin
        tx_thr <= bus_wdata[11:8];
        rx_thr <= bus_wdata[3:0];
      end
      if (wr_ien) begin
        en_rc <= bus_wdata[3];
        en_ov <= bus_wdata[0];
      end
      td_prev <= td_cond;
      rc_flag <= (rc_flag && !(wr_clr && bus_wdata[3])) || thr_hit;
      ov_flag <= (ov_flag && !(wr_clr && bus_wdata[0])) || ov_evt;
      td_flag <= (td_flag && !(wr_clr && bus_wdata[4])) || (td_cond && !td_prev);
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTL:  begin bus_rdata[11:8] = tx_thr; bus_rdata[3:0] = rx_thr; end
      A_STAT: bus_rdata[0] = rx_nempty;
      A_IEN:  begin bus_rdata[3] = en_rc; bus_rdata[0] = en_ov; end
      A_IFLG: begin
        bus_rdata[9] = thr_hit; bus_rdata[4] = td_flag;
        bus_rdata[3] = rc_flag; bus_rdata[0] = ov_flag;
      end
      A_DATA: if (rx_nempty) bus_rdata = rx_mem[rx_rp];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          tx_valid,
  input logic [DW-1:0] tx_data,
  input logic          tx_take,
  input logic          rx_push,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [3:0]    rx_thr,
  input logic          rc_flag,
  input logic          ov_flag
);
  localparam logic [AW-1:0] DATA_A = AW'(4);
  localparam logic [AW-1:0] CTL_A  = AW'(0);

  assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && 32'(rx_cnt) == DEPTH && !(bus_rd && bus_addr == DATA_A)
     && !(bus_wr && bus_addr == CTL_A && bus_wdata[4])) |=> ov_flag);

  assert_empty_pop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == DATA_A && rx_cnt == '0) |-> bus_rdata == '0);

  assert_tx_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DATA_A && 32'(tx_cnt) == DEPTH && !tx_take)
    |=> (32'(tx_cnt) == DEPTH && $stable(tx_data)));

  assert_tx_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTL_A && bus_wdata[12]) |=> !tx_valid);

  assert_thresh_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_thr != 4'd0 && 32'(rx_cnt) >= 32'(rx_thr)) |=> rc_flag);

  assert_rx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_cnt) <= DEPTH);
endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_take(tx_take), .rx_push(rx_push), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .rx_thr(rx_thr), .rc_flag(rc_flag), .ov_flag(ov_flag)
);

// File: tb/spi_fifo_irq_test.sv
module spi_fifo_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid;
  logic [31:0] tx_data;
  logic        tx_take = 1'b0, shifter_idle = 1'b1, rx_push = 1'b0;
  logic [31:0] rx_data = '0;
  logic        irq;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_fifo_irq uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); rx_push = 1; rx_data = d;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic take(input string req, input logic [31:0] exp);
    @(negedge clk);
    check(req, {31'd0, tx_valid}, 32'd1);
    check(req, tx_data, exp);
    tx_take = 1;
    @(negedge clk); tx_take = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 tx_valid", {31'd0, tx_valid}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(3'd1, v); check("R1 status", v, 0);
    rd(3'd2, v); check("R1 enable", v, 0);
    rd(3'd3, v); check("R1 flags", v, 0);
  endtask

  task automatic t_tx_order();
    for (int i = 0; i < 3; i++) wr(3'd4, 32'h1000 + i);
    for (int i = 0; i < 3; i++) take("R2 order", 32'h1000 + i);
    tick(); check("R2 empty", {31'd0, tx_valid}, 0);
  endtask

  task automatic t_tx_full();
    for (int i = 0; i < 9; i++) wr(3'd4, 32'hA0 + i);
    for (int i = 0; i < 8; i++) take("R3 full kept", 32'hA0 + i);
    tick(); check("R3 ninth dropped", {31'd0, tx_valid}, 0);
  endtask

  task automatic t_txdone();
    logic [31:0] v;
    wr(3'd3, 32'h19); tick();
    rd(3'd3, v); check("R9 w1c all", v, 0);
    shifter_idle = 0;
    wr(3'd4, 32'h55);
    take("R2 single", 32'h55);
    tick(); tick();
    rd(3'd3, v); check("R10 busy no flag", v & 32'h10, 0);
    shifter_idle = 1; tick(); tick();
    rd(3'd3, v); check("R10 tx done", v & 32'h10, 32'h10);
    wr(3'd3, 32'h10);
    rd(3'd3, v); check("R9 clear txdone", v & 32'h10, 0);
  endtask

  task automatic t_rx_order();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) push(32'hB0 + i);
    rd(3'd1, v); check("R4 not empty", v, 1);
    for (int i = 0; i < 3; i++) begin rd(3'd4, v); check("R4 order", v, 32'hB0 + i); end
    rd(3'd1, v); check("R4 empty", v, 0);
    rd(3'd4, v); check("R5 empty pop", v, 0);
    rd(3'd1, v); check("R5 still empty", v, 0);
    push(32'hC7);
    rd(3'd4, v); check("R5 no ptr move", v, 32'hC7);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    wr(3'd2, 32'h1);
    for (int i = 0; i < 9; i++) push(32'hD0 + i);
    rd(3'd3, v); check("R6 overrun flag", v & 32'h1, 1);
    check("R12 irq overrun", {31'd0, irq}, 1);
    for (int i = 0; i < 8; i++) begin rd(3'd4, v); check("R6 kept data", v, 32'hD0 + i); end
    rd(3'd1, v); check("R6 ninth discarded", v, 0);
    wr(3'd3, 32'h1); tick();
    check("R12 irq cleared", {31'd0, irq}, 0);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_pushpop_full();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) push(32'hE0 + i);
    @(negedge clk); bus_rd = 1; bus_addr = 3'd4; rx_push = 1; rx_data = 32'hEF;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0; rx_push = 0;
    check("R7 pop head", v, 32'hE0);
    rd(3'd3, v); check("R7 no overrun", v & 32'h1, 0);
    for (int i = 1; i < 8; i++) begin rd(3'd4, v); check("R7 order", v, 32'hE0 + i); end
    rd(3'd4, v); check("R7 pushed word", v, 32'hEF);
  endtask

  task automatic t_thresh();
    logic [31:0] v;
    wr(3'd0, 32'h0000_0503);
    rd(3'd0, v); check("R11 thr readback", v, 32'h0503);
    wr(3'd2, 32'h8);
    push(32'h1); push(32'h2); tick();
    rd(3'd3, v); check("R8 below thr", v & 32'h208, 0);
    push(32'h3); tick();
    rd(3'd3, v); check("R8 thr reached", v & 32'h208, 32'h208);
    check("R12 irq thr", {31'd0, irq}, 1);
    wr(3'd3, 32'h8);
    rd(3'd3, v); check("R9 set beats clear", v & 32'h8, 32'h8);
    rd(3'd4, v);
    rd(3'd3, v); check("R8 live bit low", v & 32'h200, 0);
    wr(3'd3, 32'h8);
    rd(3'd3, v); check("R9 clear rc", v & 32'h8, 0);
    check("R12 irq low", {31'd0, irq}, 0);
    wr(3'd0, 32'h0); tick();
    rd(3'd3, v); check("R8 zero thr", v & 32'h208, 0);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    rd(3'd1, v); check("R11 rx pre", v, 1);
    wr(3'd0, 32'h0000_0412);
    rd(3'd1, v); check("R11 rx flushed", v, 0);
    rd(3'd0, v); check("R11 flush bits clear", v, 32'h0402);
    wr(3'd4, 32'h77); wr(3'd4, 32'h78);
    check("R11 tx pre", {31'd0, tx_valid}, 1);
    wr(3'd0, 32'h1000);
    check("R11 tx flushed", {31'd0, tx_valid}, 0);
    wr(3'd4, 32'h79);
    take("R11 tx after flush", 32'h79);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_tx_order();
    t_tx_full();
    t_txdone();
    t_rx_order();
    t_overrun();
    t_pushpop_full();
    t_thresh();
    t_flush();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end
endmodule